// File: doc/BRIEF.md
# Stereo FM DAC Mixer with Ladder Distortion

This block produces the final left and right sample of a six-channel, four-operator FM sound generator. Each channel provides four signed operator outputs, an algorithm number and two pan enables. The algorithm decides which operators are carriers. Only carriers reach the output, and the rest are modulators that the mixer never looks at.

Per channel the block adds the carrier outputs, and it can first truncate them to 9-bit DAC resolution. It then saturates the channel to the operator range and routes it to each side the pan bits allow. A 2-bit variant selector picks the behaviour. On the discrete variant the block also adds a DC offset per channel, and that offset depends on the sign and the mute state of the channel. This models the uneven steps of that part's resistor-ladder DAC.

The surrounding sound engine presents all inputs and pulses a sample strobe. The mixed sample and a one-cycle valid pulse appear on the next clock.

Top module: `fm_dac_mixer`

## Requirements
- R1: A channel's carriers depend on its algorithm code `alg_i[3c+2:3c]`. Codes 0 to 3 use operator 4 only. Code 4 uses operators 2 and 4. Codes 5 and 6 use operators 2, 3 and 4. Code 7 uses all four operators. Operator k (1..4) of channel c is `op_i[((4c)+k-1)*14 +: 14]`, and a non-carrier operator has no effect on either output.
- R2: With `variant_i` = 0 (discrete) or 1 (integrated), the low 5 bits of each carrier value are cleared before summing. With `variant_i` = 2 (enhanced) or 3, the full 14 bits are used.
- R3: Each channel's carrier sum is clamped to the range -8192..+8191 before panning.
- R4: `pan_i[2c+1]` enables channel c on the left and `pan_i[2c]` enables it on the right. A disabled side receives 0 from that channel.
- R5: `left_o` and `right_o` are the 18-bit signed sums, over all six channels, of the clamped and panned channel values plus any ladder offsets.
- R6: On variant 0 only, each channel adds an offset to each side. If the clamped channel value is negative, the offset is -96 on an enabled side and -128 on a muted side. If the value is zero or positive, the offset is +128 on both sides.
- R7: Inputs are taken at the rising edge on which `strobe_i` is high. The new `left_o`/`right_o` and `valid_o`=1 are visible after that edge, and `valid_o` is 0 after any edge without a strobe.
- R8: Reset sets `left_o`, `right_o` and `valid_o` to 0. Between strobes the outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Sample strobe |
| variant_i | input | 2 | 0 discrete, 1 integrated, 2/3 enhanced |
| alg_i | input | 18 | Algorithm code, 3 bits per channel |
| pan_i | input | 12 | Pan enables, 2 bits per channel (left high) |
| op_i | input | 336 | Signed 14-bit operator outputs, 4 per channel |
| left_o | output | 18 | Left mixed sample, signed |
| right_o | output | 18 | Right mixed sample, signed |
| valid_o | output | 1 | One-cycle pulse with each new sample |

## Verification
The bench builds the block with its default parameters: six channels, 14-bit operators, 5 dropped DAC bits and 18-bit accumulators. With these values every carrier mask, both clamp limits and all three ladder offsets can be reached with ordinary operator values. They also allow a worst case of six saturated channels with full offsets, which shows that the accumulator has enough headroom. Directed patterns are mixed with pseudo-random operator, algorithm, pan and variant values, and each result is compared against an arithmetic model of the requirements.

// File: rtl/fm_mix_pkg.sv
package fm_mix_pkg;
  localparam int unsigned NUM_CH   = 6;
  localparam int unsigned NUM_OP   = 4;
  localparam int unsigned OP_W     = 14;
  localparam int unsigned DAC_DROP = 5;
  localparam int unsigned ACC_W    = 18;
  localparam int unsigned ALG_W    = 3;

  typedef enum logic [1:0] {
    VAR_DISCRETE   = 2'd0,
    VAR_INTEGRATED = 2'd1,
    VAR_ENHANCED   = 2'd2,
    VAR_ENH_ALT    = 2'd3
  } variant_e;

  // bit k set: operator k+1 is a carrier
  function automatic logic [3:0] carrier_mask(input logic [2:0] alg);
    case (alg)
      3'd4:         carrier_mask = 4'b1010;
      3'd5, 3'd6:   carrier_mask = 4'b1110;
      3'd7:         carrier_mask = 4'b1111;
      default:      carrier_mask = 4'b1000;
    endcase
  endfunction
endpackage

// File: rtl/fm_carrier_sum.sv
module fm_carrier_sum
  import fm_mix_pkg::*;
#(
  parameter int unsigned OPW  = OP_W,
  parameter int unsigned NOP  = NUM_OP,
  parameter int unsigned DROP = DAC_DROP
) (
  input  logic [NOP*OPW-1:0]   ops_i,
  input  logic [2:0]           alg_i,
  input  logic                 quant_i,
  output logic signed [OPW-1:0] ch_o
);
  localparam int unsigned SUM_W = OPW + $clog2(NOP) + 1;
  localparam logic signed [SUM_W-1:0] HI = SUM_W'((1 << (OPW-1)) - 1);
  localparam logic signed [SUM_W-1:0] LO = -HI - SUM_W'(1);
  localparam logic [OPW-1:0] KEEP = ~OPW'((1 << DROP) - 1);

  logic [3:0] mask;
  logic signed [SUM_W-1:0] term [NOP];
  logic signed [SUM_W-1:0] sum;

  assign mask = carrier_mask(alg_i);

  for (genvar k = 0; k < NOP; k++) begin : g_op
    logic [OPW-1:0] raw, q;
    assign raw = ops_i[k*OPW +: OPW];
    assign q   = quant_i ? (raw & KEEP) : raw;
    assign term[k] = mask[k] ? {{(SUM_W-OPW){q[OPW-1]}}, q} : '0;
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < NOP; k++) sum = sum + term[k];
  end

  always_comb begin
    if (sum > HI)      ch_o = HI[OPW-1:0];
    else if (sum < LO) ch_o = LO[OPW-1:0];
    else               ch_o = sum[OPW-1:0];
  end
endmodule

// File: rtl/fm_pan_ladder.sv
module fm_pan_ladder
  import fm_mix_pkg::*;
#(
  parameter int unsigned OPW  = OP_W,
  parameter int unsigned AW   = ACC_W,
  parameter int unsigned DROP = DAC_DROP
) (
  input  logic signed [OPW-1:0] ch_i,
  input  logic                  en_l_i,
  input  logic                  en_r_i,
  input  logic                  ladder_i,
  output logic signed [AW-1:0]  l_o,
  output logic signed [AW-1:0]  r_o
);
  localparam int UNIT = 1 << DROP;
  localparam logic signed [AW-1:0] OFS_POS  = AW'(4 * UNIT);
  localparam logic signed [AW-1:0] OFS_NEN  = AW'(-3 * UNIT);
  localparam logic signed [AW-1:0] OFS_NMUT = AW'(-4 * UNIT);

  logic signed [AW-1:0] ext;
  logic neg;

  assign ext = {{(AW-OPW){ch_i[OPW-1]}}, ch_i};
  assign neg = ch_i[OPW-1];

  function automatic logic signed [AW-1:0] side(input logic en, input logic lad,
                                                input logic n, input logic signed [AW-1:0] v);
    logic signed [AW-1:0] base, ofs;
    base = en ? v : '0;
    if (!lad)   ofs = '0;
    else if (n) ofs = en ? OFS_NEN : OFS_NMUT;
    else        ofs = OFS_POS;
    return base + ofs;
  endfunction

  assign l_o = side(en_l_i, ladder_i, neg, ext);
  assign r_o = side(en_r_i, ladder_i, neg, ext);
endmodule

// File: rtl/fm_dac_mixer.sv
module fm_dac_mixer
  import fm_mix_pkg::*;
#(
  parameter int unsigned NCH  = NUM_CH,
  parameter int unsigned NOP  = NUM_OP,
  parameter int unsigned OPW  = OP_W,
  parameter int unsigned DROP = DAC_DROP,
  parameter int unsigned AW   = ACC_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   strobe_i,
  input  logic [1:0]             variant_i,
  input  logic [NCH*ALG_W-1:0]   alg_i,
  input  logic [NCH*2-1:0]       pan_i,
  input  logic [NCH*NOP*OPW-1:0] op_i,
  output logic signed [AW-1:0]   left_o,
  output logic signed [AW-1:0]   right_o,
  output logic                   valid_o
);
  logic quant, ladder;
  logic signed [AW-1:0] ch_l [NCH];
  logic signed [AW-1:0] ch_r [NCH];
  logic signed [AW-1:0] mix_l, mix_r;

  assign quant  = (variant_i == VAR_DISCRETE) || (variant_i == VAR_INTEGRATED);
  assign ladder = (variant_i == VAR_DISCRETE);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [OPW-1:0] ch_val;
    fm_carrier_sum #(.OPW(OPW), .NOP(NOP), .DROP(DROP)) u_sum (
      .ops_i  (op_i[c*NOP*OPW +: NOP*OPW]),
      .alg_i  (alg_i[c*ALG_W +: ALG_W]),
      .quant_i(quant),
      .ch_o   (ch_val)
    );
    fm_pan_ladder #(.OPW(OPW), .AW(AW), .DROP(DROP)) u_pan (
      .ch_i    (ch_val),
      .en_l_i  (pan_i[2*c+1]),
      .en_r_i  (pan_i[2*c]),
      .ladder_i(ladder),
      .l_o     (ch_l[c]),
      .r_o     (ch_r[c])
    );
  end

  always_comb begin
    mix_l = '0;
    mix_r = '0;
    for (int c = 0; c < NCH; c++) begin
      mix_l = mix_l + ch_l[c];
      mix_r = mix_r + ch_r[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= strobe_i;
      if (strobe_i) begin
        left_o  <= mix_l;
        right_o <= mix_r;
      end
    end
  end
endmodule

// File: rtl/fm_dac_mixer_chk.sv
module fm_dac_mixer_chk #(
  parameter int unsigned NCH  = 6,
  parameter int unsigned OPW  = 14,
  parameter int unsigned DROP = 5,
  parameter int unsigned AW   = 18
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 strobe_i,
  input logic [1:0]           variant_i,
  input logic [NCH*2-1:0]     pan_i,
  input logic signed [AW-1:0] left_o,
  input logic signed [AW-1:0] right_o,
  input logic                 valid_o
);
  localparam int BOUND_I = NCH * ((1 << (OPW-1)) + 4 * (1 << DROP));
  localparam logic signed [AW-1:0] BOUND = AW'(BOUND_I);

  a_r7_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> valid_o);
  a_r7_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> !valid_o);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> ($stable(left_o) && $stable(right_o)));
  a_r4_all_muted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && pan_i == '0 && variant_i != 2'd0) |=> (left_o == '0 && right_o == '0));
  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (left_o <= BOUND && left_o >= -BOUND && right_o <= BOUND && right_o >= -BOUND));
endmodule

bind fm_dac_mixer fm_dac_mixer_chk #(.NCH(NCH), .OPW(OPW), .DROP(DROP), .AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .strobe_i (strobe_i),
  .variant_i(variant_i),
  .pan_i    (pan_i),
  .left_o   (left_o),
  .right_o  (right_o),
  .valid_o  (valid_o)
);

// File: tb/fm_dac_mixer_bench.sv
module fm_dac_mixer_bench;
  localparam int NCH = 6, NOP = 4, OPW = 14, AW = 18;

  logic clk = 0, rst_n = 0, strobe = 0;
  logic [1:0] variant = 2'd2;
  logic [NCH*3-1:0] alg_v;
  logic [NCH*2-1:0] pan_v;
  logic [NCH*NOP*OPW-1:0] op_v;
  logic signed [AW-1:0] left, right;
  logic valid;

  int opv [NCH][NOP];
  int algs [NCH];
  int pans [NCH];
  int n_chk = 0, n_fail = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      alg_v[c*3 +: 3] = 3'(algs[c]);
      pan_v[c*2 +: 2] = 2'(pans[c]);
      for (int k = 0; k < NOP; k++) op_v[(c*NOP+k)*OPW +: OPW] = OPW'(opv[c][k]);
    end
  end

  fm_dac_mixer u_fm_dac_mixer (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .variant_i(variant),
    .alg_i(alg_v), .pan_i(pan_v), .op_i(op_v),
    .left_o(left), .right_o(right), .valid_o(valid)
  );

  function automatic bit is_car(int a, int k);
    if (a <= 3) return k == 3;
    if (a == 4) return k == 1 || k == 3;
    if (a <= 6) return k >= 1;
    return 1;
  endfunction

  function automatic int model(bit lft);
    int acc = 0;
    for (int c = 0; c < NCH; c++) begin
      int s = 0, v;
      bit en;
      for (int k = 0; k < NOP; k++) if (is_car(algs[c], k)) begin
        v = opv[c][k];
        if (variant <= 1) v = v & ~31;
        s += v;
      end
      if (s > 8191) s = 8191;
      if (s < -8192) s = -8192;
      en = lft ? pans[c][1] : pans[c][0];
      if (en) acc += s;
      if (variant == 0) begin
        if (s < 0) acc -= en ? 96 : 128;
        else acc += 128;
      end
    end
    return acc;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_in();
    for (int c = 0; c < NCH; c++) begin
      algs[c] = 0; pans[c] = 0;
      for (int k = 0; k < NOP; k++) opv[c][k] = 0;
    end
  endtask

  task automatic fire();
    @(negedge clk) strobe = 1;
    @(negedge clk) strobe = 0;
  endtask

  task automatic fire_check(string req, int el, int er);
    fire();
    check({req, " valid"}, int'(valid), 1);
    check({req, " left"}, int'(left), el);
    check({req, " right"}, int'(right), er);
  endtask

  task automatic t_reset();
    check("R8 reset left", int'(left), 0);
    check("R8 reset right", int'(right), 0);
    check("R8 reset valid", int'(valid), 0);
  endtask

  task automatic t_carriers();
    variant = 2'd2;
    for (int a = 0; a < 8; a++) begin
      clear_in();
      algs[0] = a; pans[0] = 3;
      opv[0][0] = 1; opv[0][1] = 10; opv[0][2] = 100; opv[0][3] = 1000;
      fire_check("R1 carriers", model(1), model(0));
    end
    clear_in();
    algs[1] = 2; pans[1] = 2;
    opv[1][0] = 5000; opv[1][1] = -5000; opv[1][2] = 4000; opv[1][3] = 100;
    fire_check("R1 modulators ignored", 100, 0);
  endtask

  task automatic t_quant();
    clear_in();
    algs[0] = 0; pans[0] = 3; opv[0][3] = 63;
    variant = 2'd1; fire_check("R2 integrated truncates", 32, 32);
    opv[0][3] = -63; fire_check("R2 integrated negative", -64, -64);
    opv[0][3] = 63;
    variant = 2'd2; fire_check("R2 enhanced full", 63, 63);
    variant = 2'd3; fire_check("R2 code3 full", 63, 63);
  endtask

  task automatic t_clamp();
    variant = 2'd2; clear_in();
    algs[0] = 7; pans[0] = 3;
    for (int k = 0; k < NOP; k++) opv[0][k] = 8000;
    fire_check("R3 clamp high", 8191, 8191);
    for (int k = 0; k < NOP; k++) opv[0][k] = -8000;
    fire_check("R3 clamp low", -8192, -8192);
  endtask

  task automatic t_pan();
    variant = 2'd2; clear_in();
    pans[2] = 2; opv[2][3] = 500;
    fire_check("R4 left only", 500, 0);
    pans[2] = 1;
    fire_check("R4 right only", 0, 500);
  endtask

  task automatic t_sum();
    variant = 2'd2; clear_in();
    for (int c = 0; c < NCH; c++) begin pans[c] = 3; opv[c][3] = 1000 * (c + 1); end
    fire_check("R5 six channel sum", 21000, 21000);
    for (int c = 0; c < NCH; c++) begin algs[c] = 7; for (int k = 0; k < NOP; k++) opv[c][k] = 8191; end
    fire_check("R5 full scale", 6 * 8191, 6 * 8191);
  endtask

  task automatic t_ladder();
    variant = 2'd0; clear_in();
    fire_check("R6 zero muted", 768, 768);
    pans[0] = 2; opv[0][3] = -64;
    fire_check("R6 negative enabled/muted", 480, 512);
    variant = 2'd1;
    fire_check("R6 no ladder integrated", -64, 0);
    variant = 2'd0; clear_in();
    for (int c = 0; c < NCH; c++) begin algs[c] = 7; pans[c] = 3; for (int k = 0; k < NOP; k++) opv[c][k] = -8192; end
    fire_check("R6 worst negative", 6 * (-8192 - 96), 6 * (-8192 - 96));
  endtask

  task automatic t_hold();
    int el, er;
    variant = 2'd2; clear_in();
    pans[3] = 3; opv[3][3] = 777;
    fire_check("R7 load", 777, 777);
    el = int'(left); er = int'(right);
    opv[3][3] = -1234; variant = 2'd0;
    @(negedge clk);
    check("R7 valid drops", int'(valid), 0);
    @(negedge clk);
    check("R8 hold left", int'(left), el);
    check("R8 hold right", int'(right), er);
  endtask

  task automatic t_random();
    for (int i = 0; i < 200; i++) begin
      variant = 2'(seed[1:0]);
      for (int c = 0; c < NCH; c++) begin
        seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
        algs[c] = int'(seed[2:0]); pans[c] = int'(seed[4:3]);
        for (int k = 0; k < NOP; k++) begin
          seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
          opv[c][k] = int'($signed(seed[13:0]));
        end
      end
      fire_check("R5 random mix", model(1), model(0));
    end
  endtask

  initial begin
    clear_in();
    #1;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_carriers();
    t_quant();
    t_clamp();
    t_pan();
    t_sum();
    t_ladder();
    t_hold();
    t_random();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule